// File: doc/BRIEF.md
# Serial Line Encoder with Symbol Clock Divider

This block is the digital transmit path of a 100 Mb/s copper physical layer. It runs entirely from one 125 MHz bit clock and produces, by dividing that clock by five, the 25 MHz symbol clock that the upstream coding logic uses to present 5-bit code groups. Each group is captured into a staging register at the symbol clock's rising edge. It is then moved into a parallel-in serial-out shifter and sent one bit per bit-clock cycle, least significant bit first, with no idle cycle between groups.

The last stage of the shifter turns the serial NRZ bits into NRZI, where a one flips the line state and a zero keeps it. A four-state sequencer then maps each NRZI flip onto the next step of a three-level MLT-3 waveform. The result leaves the block as a signed two-bit level, ready for an analog driver. An output enable forces the line to the middle level without disturbing the encoder state.

The reset is asynchronous and active low. Its deassertion is expected to be synchronous to the bit clock.

Top module: `sym_tx_serializer`

## Requirements
- R1: `symclk_o` is periodic with exactly five bit-clock cycles per period, high for two cycles and low for three. Its first rise follows the first clock edge after reset is released.
- R2: `sym_i` is sampled only at the bit-clock edge where `symclk_o` rises. Values present at any other edge have no effect on the line output.
- R3: A group sampled at a symbol clock rise is sent bit 0 first. Bit k shows on `line_o` at the (3+k)-th bit-clock edge after the sampling edge, and consecutive groups follow with no gap.
- R4: A serial one causes exactly one step of the line level at its bit time. A serial zero leaves the level unchanged.
- R5: The line level steps cyclically through 0, +1, 0, -1. It is encoded on `line_o` as 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. The code 2'b10 never appears.
- R6: While `oe_i` is low, `line_o` is 2'b00, but the encoder keeps advancing. When `oe_i` returns high, the level reflects every one bit sent in the meantime.
- R7: During reset, `symclk_o` is low and `line_o` is 2'b00. After reset the sequencer starts at the first 0 state, and the staging register and shifter hold zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 125 MHz bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sym_i | input | SYM_W | NRZ code group from upstream logic |
| oe_i | input | 1 | Line output enable |
| symclk_o | output | 1 | Divided symbol clock for upstream logic |
| line_o | output | 2 | MLT-3 line level, signed two-bit code |

## Verification
The hardest situation to reach from the ports is a symbol boundary where the staging register, shifter and sequencer all change at nearly the same edge. There, a wrong load phase or an extra idle cycle would only show up as a misplaced level step. The bench sends every ordered pair of the 32 possible code groups back to back, so every boundary combination of trailing and leading bits occurs. Between sampling edges it changes `sym_i` to unrelated values, and it turns the output enable off for single symbols so that the hidden sequencer state must be correct when the line comes back.

// File: rtl/sym_tx_pkg.sv
package sym_tx_pkg;

  // MLT-3 sequencer states, in stepping order
  typedef enum logic [1:0] {
    MLT_ZERO_A = 2'd0,
    MLT_POS    = 2'd1,
    MLT_ZERO_B = 2'd2,
    MLT_NEG    = 2'd3
  } mlt_state_e;

  typedef logic [1:0] line_lvl_t;

  localparam line_lvl_t LVL_ZERO = 2'b00;
  localparam line_lvl_t LVL_POS  = 2'b01;
  localparam line_lvl_t LVL_NEG  = 2'b11;

endpackage

// File: rtl/symclk_div.sv
module symclk_div #(
  parameter int RATIO = 5,
  parameter int HIGH  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic symclk_o,
  output logic cap_en_o,
  output logic load_en_o
);

  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RATIO - 1);
  localparam logic [CNT_W-1:0] CNT_HIGH = CNT_W'(HIGH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;

  always_comb begin
    cnt_d  = (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
    sclk_d = (cnt_d < CNT_HIGH);
  end

  // reset to the last phase so the first edge starts a symbol period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_LAST;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign symclk_o  = sclk_q;
  assign cap_en_o  = (cnt_q == CNT_LAST);   // edge where symclk rises
  assign load_en_o = (cnt_q == '0);         // edge right after capture

endmodule

// File: rtl/sym_piso_nrzi.sv
module sym_piso_nrzi #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sym_i,
  input  logic         cap_en_i,
  input  logic         load_en_i,
  output logic [W-1:0] hold_o,
  output logic         ser_bit_o,
  output logic         nrzi_o
);

  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] shf_q, shf_d;
  logic         nrzi_q, nrzi_d;

  always_comb begin
    hold_d = hold_q;
    if (cap_en_i) hold_d = sym_i;
  end

  always_comb begin
    if (load_en_i) shf_d = hold_q;
    else           shf_d = {1'b0, shf_q[W-1:1]};
    // last stage: NRZ one flips the NRZI level
    nrzi_d = nrzi_q ^ shf_q[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      shf_q  <= '0;
      nrzi_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      shf_q  <= shf_d;
      nrzi_q <= nrzi_d;
    end
  end

  assign hold_o    = hold_q;
  assign ser_bit_o = shf_q[0];
  assign nrzi_o    = nrzi_q;

endmodule

// File: rtl/mlt3_seq.sv
module mlt3_seq
  import sym_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      nrzi_i,
  input  logic      oe_i,
  output line_lvl_t line_o
);

  mlt_state_e st_q, st_d;
  logic       prev_q;
  logic       step;

  assign step = (nrzi_i != prev_q);

  always_comb begin
    st_d = st_q;
    if (step) st_d = mlt_state_e'(st_q + 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= MLT_ZERO_A;
      prev_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      prev_q <= nrzi_i;
    end
  end

  always_comb begin
    line_o = LVL_ZERO;
    if (oe_i) begin
      case (st_q)
        MLT_POS: line_o = LVL_POS;
        MLT_NEG: line_o = LVL_NEG;
        default: line_o = LVL_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/sym_tx_serializer.sv
module sym_tx_serializer
  import sym_tx_pkg::*;
#(
  parameter int SYM_W     = 5,
  parameter int SCLK_HIGH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             oe_i,
  output logic             symclk_o,
  output logic [1:0]       line_o
);

  logic             cap_en_w;
  logic             load_en_w;
  logic [SYM_W-1:0] hold_w;
  logic             ser_bit_w;
  logic             nrzi_w;

  symclk_div #(
    .RATIO (SYM_W),
    .HIGH  (SCLK_HIGH)
  ) div_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .symclk_o  (symclk_o),
    .cap_en_o  (cap_en_w),
    .load_en_o (load_en_w)
  );

  sym_piso_nrzi #(
    .W (SYM_W)
  ) piso_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sym_i     (sym_i),
    .cap_en_i  (cap_en_w),
    .load_en_i (load_en_w),
    .hold_o    (hold_w),
    .ser_bit_o (ser_bit_w),
    .nrzi_o    (nrzi_w)
  );

  mlt3_seq mlt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nrzi_i (nrzi_w),
    .oe_i   (oe_i),
    .line_o (line_o)
  );

endmodule

// File: rtl/sym_tx_checker.sv
module sym_tx_checker #(
  parameter int W = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         oe_i,
  input logic         symclk_o,
  input logic [1:0]   line_o,
  input logic         nrzi_i,
  input logic         ser_bit_i,
  input logic [W-1:0] hold_i
);

  // R5
  line_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o != 2'b10);

  // R6
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> line_o == 2'b00);

  // R1
  symclk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(symclk_o) |=> symclk_o ##1 !symclk_o);

  // R5
  no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && $past(oe_i) && line_o != $past(line_o)) |->
      (line_o == 2'b00 || $past(line_o) == 2'b00));

  // R4
  nrzi_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrzi_i != $past(nrzi_i)) |-> $past(ser_bit_i));

  // R2
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(symclk_o) |-> $stable(hold_i));

endmodule

bind sym_tx_serializer sym_tx_checker #(.W(SYM_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oe_i      (oe_i),
  .symclk_o  (symclk_o),
  .line_o    (line_o),
  .nrzi_i    (nrzi_w),
  .ser_bit_i (ser_bit_w),
  .hold_i    (hold_w)
);

// File: tb/sym_tx_serializer_tb_top.sv
module sym_tx_serializer_tb_top;

  localparam int CLK_PERIOD = 8;
  localparam int N_SYMS     = 2048 + 8;
  localparam int WDOG_CYC   = 150000;

  logic       clk_i;
  logic       rst_ni;
  logic [4:0] sym_i;
  logic       oe_i;
  logic       symclk_o;
  logic [1:0] line_o;

  int n_chk;
  int n_fail;
  bit done;

  sym_tx_serializer dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sym_i    (sym_i),
    .oe_i     (oe_i),
    .symclk_o (symclk_o),
    .line_o   (line_o)
  );

  initial clk_i = 1'b0;
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every ordered pair of code groups, then a run of all-ones
  function automatic logic [4:0] sym_of(input int n);
    int p;
    if (n < 2048) begin
      p = n / 2;
      return (n % 2 == 1) ? 5'(p % 32) : 5'(p / 32);
    end
    return 5'h1F;
  endfunction

  function automatic logic [1:0] lvl_of(input int ones);
    case (ones % 4)
      1:       return 2'b01;
      3:       return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  initial begin
    logic [4:0] prev_cap, cur_cap;
    logic [1:0] exp_l;
    logic       sclk_prev, bitv;
    int   phase, ones, since, high, k;
    bit   started, rise;
    string tag;

    n_chk = 0; n_fail = 0; done = 0;
    rst_ni = 1'b0; sym_i = 5'h15; oe_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk(symclk_o == 1'b0, "R7 symclk in reset", int'(symclk_o), 0);
      chk(line_o == 2'b00, "R7 line in reset", int'(line_o), 0);
    end
    @(negedge clk_i);
    sym_i = sym_of(0); k = 1; rst_ni = 1'b1;
    sclk_prev = 1'b0; started = 0; ones = 0; phase = 0; since = 0; high = 0;
    prev_cap = '0; cur_cap = '0;

    while (k < N_SYMS) begin
      @(negedge clk_i);
      since++;
      rise = symclk_o && !sclk_prev;
      if (!started) begin
        chk(rise, "R1 first symclk rise", int'(symclk_o), 1);
      end
      if (rise) begin
        if (started) begin
          chk(since == 5, "R1 symclk period", since, 5);
          chk(high == 2, "R1 symclk high time", high, 2);
        end
        since = 0; high = 1;
        prev_cap = cur_cap; cur_cap = sym_i;   // value held at the capture edge
        phase = 0; started = 1;
      end else begin
        if (symclk_o) high++;
        phase++;
      end
      if (started) begin
        bitv = (phase < 3) ? prev_cap[phase + 2] : cur_cap[phase - 3];
        if (bitv) ones++;
        exp_l = oe_i ? lvl_of(ones) : 2'b00;
        if (!oe_i)               tag = "R6 line while disabled";
        else if (ones % 4 == 3)  tag = "R5 negative level";
        else if (bitv)           tag = "R4 step on one";
        else                     tag = "R2 R3 serial order";
        chk(line_o == exp_l, tag, int'(line_o), int'(exp_l));
      end
      sclk_prev = symclk_o;
      // drive: real symbol before the capture edge, junk elsewhere
      if (started && phase == 4) begin
        sym_i = sym_of(k);
        oe_i  = (k % 7) != 3;
        k++;
      end else if (started) begin
        sym_i = 5'((k * 13 + phase * 7 + 5) % 32);
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule